// File: doc/BRIEF.md
# Configuration Store with Readback Lock

This block holds every configuration bit of a small programmable logic device. That state has five parts. There is a 40 by 40 grid of array fuses. There are three control bits for each of ten output macrocells: a polarity bit and two architecture bits. There is one global mode bit and a 40-bit user signature. Every stored bit is driven out in parallel on configuration ports, so the logic fabric can use it directly.

A programmer reaches the store through one command stream. The commands are set-bit, read-bit, erase and lock. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A read returns one result beat on `rsp_valid`/`rsp_ready`. That beat is held until it is consumed.

`cmd_ready` is low in two cases: while a result is still waiting to be taken, and while an erase is running. This is the only back-pressure. The sender holds its command until `cmd_ready` rises.

Once the lock is set, reads of the logic pattern are refused. Reads of the signature still work. Only an erase takes the lock away. An erase is the first step of every programming pass, and after it, writes can only turn bits on.

Top module: `cfgs_top`

## Requirements
- R1: After reset, every configuration output, `secured`, `busy` and `rsp_valid` are 0, while `cmd_ready` and `cfg_valid` are 1.
- R2: The store uses linear bit addresses, and a set-bit of address a shows up on the configuration outputs the cycle after acceptance. The address map is: 0..1599 to `cfg_array[a]`, 1600+i to `cfg_pol[i]`, 1610+i to `cfg_ac0[i]`, 1620+i to `cfg_ac1[i]`, 1630 to `cfg_mode`, and 1631+j to `cfg_sig[j]`.
- R3: Op code 2'b00 is set-bit. It ORs `cmd_wdata` into the addressed bit, so writing 0 leaves a bit unchanged and no write clears a bit.
- R4: Op code 2'b01 is read. The cycle after acceptance, `rsp_valid` rises with the stored bit on `rsp_data`, and `rsp_denied` is 0 while unlocked.
- R5: Op code 2'b11 sets the lock (`secured`=1). After that, a read of any address from 0 to 1630 returns `rsp_data`=0 with `rsp_denied`=1.
- R6: A read of a signature address (1631..1670) returns the stored bit with `rsp_denied`=0, whatever the lock state.
- R7: Op code 2'b10 is erase. In one step it clears every bit, including signature, mode and lock. `busy` is then high for ERASE_CYC cycles (default 4), starting the cycle after acceptance. During those cycles `cmd_ready` and `cfg_valid` are low.
- R8: Once set, `secured` stays 1 through set-bit, read and lock commands, and is cleared only by erase.
- R9: A result beat keeps `rsp_valid`, `rsp_data` and `rsp_denied` stable until `rsp_ready` is high. No command is accepted while a beat is pending.
- R10: Addresses 1671 and above are outside the store. A set-bit to them changes nothing, and a read of them returns 0 with `rsp_denied`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all state |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 00 set-bit, 01 read, 10 erase, 11 lock |
| cmd_addr | input | 11 | Linear bit address |
| cmd_wdata | input | 1 | Value ORed in by set-bit |
| rsp_valid | output | 1 | Read result beat present |
| rsp_ready | input | 1 | Result beat consumed this cycle |
| rsp_data | output | 1 | Read bit (0 when refused) |
| rsp_denied | output | 1 | Read refused by lock |
| busy | output | 1 | Erase in progress |
| cfg_valid | output | 1 | Configuration outputs usable |
| secured | output | 1 | Lock state |
| cfg_array | output | 1600 | Array fuses, row-major |
| cfg_pol | output | 10 | Per-macrocell polarity bits |
| cfg_ac0 | output | 10 | Per-macrocell first architecture bits |
| cfg_ac1 | output | 10 | Per-macrocell second architecture bits |
| cfg_mode | output | 1 | Global mode bit |
| cfg_sig | output | 40 | User signature |

## Verification
A set-bit appears on the configuration outputs the cycle after its handshake. A read beat is due the cycle after its handshake and then waits for `rsp_ready`. `busy` covers exactly the ERASE_CYC cycles that follow an erase handshake. The bench drives inputs on the falling edge and samples shortly after that edge. It checks the configuration image directly after each accepting edge. A scoreboard queue matches every read beat, and is the only place a read beat is compared. It matches each beat at the handshake where it is consumed, and checks it stays stable through the stalls inserted before that handshake. The bench counts high `busy` cycles one by one after each erase.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [1:0] {
    OP_SET   = 2'b00,
    OP_READ  = 2'b01,
    OP_ERASE = 2'b10,
    OP_LOCK  = 2'b11
  } cfg_op_e;
endpackage

// File: rtl/cfgs_store.sv
module cfgs_store #(
  parameter int TOTAL  = 1671,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic              lock_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic [TOTAL-1:0]  bits,
  output logic              secure
);
  logic in_range;
  assign in_range = int'(addr) < TOTAL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits   <= '0;
      secure <= 1'b0;
    end else if (clr_en) begin
      bits   <= '0;
      secure <= 1'b0;
    end else begin
      if (set_en && in_range && wdata) bits[addr] <= 1'b1;
      if (lock_en) secure <= 1'b1;
    end
  end

  // R7: erase leaves nothing set, lock included
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (bits == '0 && !secure));
  // R3: without erase no bit ever falls
  assert_set_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((bits & $past(bits)) == $past(bits)));
  // R8: lock is sticky until erase
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (secure && !clr_en) |=> secure);
endmodule

// File: rtl/cfgs_read_gate.sv
module cfgs_read_gate #(
  parameter int TOTAL    = 1671,
  parameter int SIG_BASE = 1631,
  parameter int ADDR_W   = 11
) (
  input  logic [TOTAL-1:0]  bits,
  input  logic              secure,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_bit,
  output logic              rd_deny
);
  logic in_range, shielded;
  assign in_range = int'(addr) < TOTAL;
  assign shielded = int'(addr) < SIG_BASE;
  assign rd_deny  = secure && shielded;
  assign rd_bit   = in_range && !rd_deny && bits[addr];
endmodule

// File: rtl/cfgs_ctrl.sv
module cfgs_ctrl import cfgs_pkg::*; #(
  parameter int ERASE_CYC = 4,
  localparam int CW = $clog2(ERASE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       rsp_ready,
  input  logic       rd_bit,
  input  logic       rd_deny,
  output logic       cmd_ready,
  output logic       set_en,
  output logic       clr_en,
  output logic       lock_en,
  output logic       rsp_valid,
  output logic       rsp_data,
  output logic       rsp_denied,
  output logic       busy
);
  logic [CW-1:0] cnt;
  logic          fire, rd_en;

  assign busy      = cnt != '0;
  assign cmd_ready = !busy && !rsp_valid;
  assign fire      = cmd_valid && cmd_ready;
  assign set_en    = fire && cmd_op == OP_SET;
  assign rd_en     = fire && cmd_op == OP_READ;
  assign clr_en    = fire && cmd_op == OP_ERASE;
  assign lock_en   = fire && cmd_op == OP_LOCK;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr_en) cnt <= CW'(ERASE_CYC);
    else if (busy)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= 1'b0;
      rsp_denied <= 1'b0;
    end else if (rd_en) begin
      rsp_valid  <= 1'b1;
      rsp_data   <= rd_bit;
      rsp_denied <= rd_deny;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  // R9: a stalled beat does not move
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_denied)));
  // R7: erase acceptance starts the busy window
  assert_erase_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> busy);
  // R5: a refused beat carries no data
  assert_deny_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_denied) |-> !rsp_data);
endmodule

// File: rtl/cfgs_top.sv
module cfgs_top import cfgs_pkg::*; #(
  parameter int ROWS      = 40,
  parameter int COLS      = 40,
  parameter int CELLS     = 10,
  parameter int SIG_W     = 40,
  parameter int ERASE_CYC = 4,
  parameter int ADDR_W    = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic                   cmd_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_data,
  output logic                   rsp_denied,
  output logic                   busy,
  output logic                   cfg_valid,
  output logic                   secured,
  output logic [ROWS*COLS-1:0]   cfg_array,
  output logic [CELLS-1:0]       cfg_pol,
  output logic [CELLS-1:0]       cfg_ac0,
  output logic [CELLS-1:0]       cfg_ac1,
  output logic                   cfg_mode,
  output logic [SIG_W-1:0]       cfg_sig
);
  localparam int ARR_N     = ROWS * COLS;
  localparam int POL_BASE  = ARR_N;
  localparam int AC0_BASE  = POL_BASE + CELLS;
  localparam int AC1_BASE  = AC0_BASE + CELLS;
  localparam int MODE_ADDR = AC1_BASE + CELLS;
  localparam int SIG_BASE  = MODE_ADDR + 1;
  localparam int TOTAL     = SIG_BASE + SIG_W;

  logic [TOTAL-1:0] bits;
  logic set_en, clr_en, lock_en, rd_bit, rd_deny;

  cfgs_ctrl #(.ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_ready(rsp_ready), .rd_bit(rd_bit), .rd_deny(rd_deny),
    .cmd_ready(cmd_ready), .set_en(set_en), .clr_en(clr_en), .lock_en(lock_en),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied), .busy(busy)
  );

  cfgs_store #(.TOTAL(TOTAL), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en), .lock_en(lock_en),
    .addr(cmd_addr), .wdata(cmd_wdata), .bits(bits), .secure(secured)
  );

  cfgs_read_gate #(.TOTAL(TOTAL), .SIG_BASE(SIG_BASE), .ADDR_W(ADDR_W)) u_gate (
    .bits(bits), .secure(secured), .addr(cmd_addr), .rd_bit(rd_bit), .rd_deny(rd_deny)
  );

  assign cfg_valid = !busy;
  assign cfg_array = bits[0 +: ARR_N];
  assign cfg_pol   = bits[POL_BASE +: CELLS];
  assign cfg_ac0   = bits[AC0_BASE +: CELLS];
  assign cfg_ac1   = bits[AC1_BASE +: CELLS];
  assign cfg_mode  = bits[MODE_ADDR];
  assign cfg_sig   = bits[SIG_BASE +: SIG_W];

  // R6: signature reads are never refused
  assert_sig_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_READ &&
     int'(cmd_addr) >= SIG_BASE && int'(cmd_addr) < TOTAL) |=> (rsp_valid && !rsp_denied));
endmodule

// File: tb/tb_cfgs_top.sv
module tb_cfgs_top;
  localparam int TOTAL = 1671;
  localparam int SIGB  = 1631;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_wdata = 0, rsp_ready = 1;
  logic [1:0] cmd_op = 0;
  logic [10:0] cmd_addr = 0;
  logic cmd_ready, rsp_valid, rsp_data, rsp_denied, busy, cfg_valid, secured, cfg_mode;
  logic [1599:0] cfg_array;
  logic [9:0] cfg_pol, cfg_ac0, cfg_ac1;
  logic [39:0] cfg_sig;

  cfgs_top dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit mdl [TOTAL];
  bit msec = 0;
  bit stall = 0;
  int rcnt = 0;
  bit q_data[$];
  bit q_den[$];
  string q_req[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // configuration image in address order against the model
  task automatic chk_img(input string req);
    logic [TOTAL-1:0] img;
    int bad;
    img = {cfg_sig, cfg_mode, cfg_ac1, cfg_ac0, cfg_pol, cfg_array};
    bad = -1;
    for (int a = 0; a < TOTAL; a++) if (bad < 0 && img[a] !== mdl[a]) bad = a;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s image at address %0d: actual %0b expected %0b", req, bad, img[bad], mdl[bad]);
    end
  endtask

  // driver: offers one command, pushes the expected result for reads
  task automatic issue(input logic [1:0] op, input int addr, input bit d, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = 11'(addr); cmd_wdata = d;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 cmd_valid = 0;
    case (op)
      2'b00: if (addr < TOTAL && d) mdl[addr] = 1;
      2'b01: begin
        bit den;
        den = msec && addr < SIGB;
        q_den.push_back(den);
        q_data.push_back((addr < TOTAL && !den) ? mdl[addr] : 1'b0);
        q_req.push_back(req);
      end
      2'b10: begin
        for (int a = 0; a < TOTAL; a++) mdl[a] = 0;
        msec = 0;
      end
      default: msec = 1;
    endcase
  endtask

  always @(negedge clk) begin
    rcnt++;
    rsp_ready <= stall ? (rcnt % 3 == 0) : 1'b1;
  end

  // monitor: compares beats at their handshake, watches stalled beats
  bit held_v = 0, held_d = 0, held_n = 0;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (held_v) begin
          chk("R9", "stalled beat valid", rsp_valid, 1);
          chk("R9", "stalled beat data", rsp_data, held_d);
          chk("R9", "stalled beat denied", rsp_denied, held_n);
        end
        if (rsp_valid && rsp_ready) begin
          if (q_data.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R4 unexpected beat: actual %0b expected none", rsp_data);
          end else begin
            string r;
            bit ed, en;
            r = q_req.pop_front(); ed = q_data.pop_front(); en = q_den.pop_front();
            chk(r, "read data", rsp_data, ed);
            chk(r, "read denied", rsp_denied, en);
          end
          held_v = 0;
        end else begin
          held_v = rsp_valid; held_d = rsp_data; held_n = rsp_denied;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < TOTAL; a++) mdl[a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk_img("R1");
    chk("R1", "secured", secured, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "cfg_valid", cfg_valid, 1);

    // R2 address map through each field edge
    issue(2'b00, 0, 1, "R2");    chk("R2", "array[0]", cfg_array[0], 1);
    issue(2'b00, 1599, 1, "R2"); chk("R2", "array[1599]", cfg_array[1599], 1);
    issue(2'b00, 837, 1, "R2");
    issue(2'b00, 1600, 1, "R2"); chk("R2", "pol[0]", cfg_pol[0], 1);
    issue(2'b00, 1609, 1, "R2"); chk("R2", "pol[9]", cfg_pol[9], 1);
    issue(2'b00, 1613, 1, "R2"); chk("R2", "ac0[3]", cfg_ac0[3], 1);
    issue(2'b00, 1627, 1, "R2"); chk("R2", "ac1[7]", cfg_ac1[7], 1);
    issue(2'b00, 1630, 1, "R2"); chk("R2", "mode", cfg_mode, 1);
    issue(2'b00, 1631, 1, "R2"); chk("R2", "sig[0]", cfg_sig[0], 1);
    issue(2'b00, 1670, 1, "R2"); chk("R2", "sig[39]", cfg_sig[39], 1);
    chk_img("R2");

    // R3 zero write cannot clear
    issue(2'b00, 837, 0, "R3");  chk("R3", "array[837] kept", cfg_array[837], 1);
    issue(2'b00, 900, 0, "R3");
    chk_img("R3");

    // R4 reads, set and unset
    issue(2'b01, 837, 0, "R4");
    issue(2'b01, 838, 0, "R4");
    issue(2'b01, 1630, 0, "R4");
    issue(2'b01, 1613, 0, "R4");
    drain();

    // R10 outside the store
    issue(2'b00, 1671, 1, "R10");
    issue(2'b00, 2047, 1, "R10");
    chk_img("R10");
    issue(2'b01, 2000, 0, "R10");
    drain();

    // R9 back-pressure on results
    stall = 1;
    issue(2'b01, 0, 0, "R9");
    issue(2'b01, 1, 0, "R9");
    issue(2'b01, 1609, 0, "R9");
    issue(2'b01, 1670, 0, "R9");
    drain();
    stall = 0;

    // R5 lock refuses pattern reads; R6 signature stays open
    issue(2'b11, 0, 0, "R5");
    chk("R5", "secured", secured, 1);
    issue(2'b01, 837, 0, "R5");
    issue(2'b01, 1630, 0, "R5");
    issue(2'b01, 0, 0, "R5");
    issue(2'b01, 1631, 0, "R6");
    issue(2'b01, 1670, 0, "R6");
    issue(2'b01, 1650, 0, "R6");
    drain();

    // R8 lock survives other commands
    issue(2'b00, 1650, 1, "R8");
    issue(2'b11, 0, 0, "R8");
    issue(2'b01, 1650, 0, "R8");
    drain();
    chk("R8", "secured held", secured, 1);
    chk_img("R8");

    // R7 erase clears everything, busy window
    issue(2'b10, 0, 0, "R7");
    chk_img("R7");
    chk("R7", "secured cleared", secured, 0);
    begin
      int nb;
      nb = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #1;
        if (busy) begin
          nb++;
          chk("R7", "cmd_ready while busy", cmd_ready, 0);
          chk("R7", "cfg_valid while busy", cfg_valid, 0);
        end
      end
      chk("R7", "busy cycles", nb, 4);
    end
    chk("R7", "cfg_valid after erase", cfg_valid, 1);
    issue(2'b01, 837, 0, "R7");
    issue(2'b01, 1670, 0, "R7");
    drain();

    // R4 programming pass after erase
    issue(2'b00, 1234, 1, "R4");
    issue(2'b01, 1234, 0, "R4");
    drain();
    chk_img("R4");

    report();
  end
endmodule